// File: doc/BRIEF.md
# Event Input Noise Rejector

This block cleans up an external event-clock pin before the pin clocks an event down counter. The raw pin first passes through a synchronizer. When filtering is on, a new pin level is taken over only after it has held until the second falling edge of a slow sampling strobe, nominally 2,048 Hz. Contact chatter and other short glitches therefore never reach the counter. When filtering is off, the synchronized pin is taken over on every system clock.

A polarity bit chooses which edge of the accepted level is a count. The block emits a pulse one system clock wide for each accepted edge of that kind. The counter then decrements on that pulse. The sampling strobe comes from elsewhere and is treated here as an asynchronous level.

Top module: `evt_noise_filter`

## Requirements
- R1: After reset the accepted level is high and `countPulse` is 0. Holding the pin high after reset produces no pulse.
- R2: With `filterEn` = 0 the pin goes through a two-stage synchronizer and is accepted directly. A qualifying pin change that is set up before clock edge 1 gives `countPulse` = 1 after edge 3 and not before.
- R3: With `filterEn` = 1 a changed level is accepted at the second falling edge of `sampleRef` seen after the synchronized change. The pulse appears more than one strobe period and less than 2.5 strobe periods after the pin change.
- R4: With `filterEn` = 1 a pin pulse shorter than one strobe period sees at most one strobe falling edge and gives no pulse.
- R5: If the pin returns to the accepted level before the second strobe falling edge, the pending change is dropped and the falling-edge count restarts from zero. Continuous chatter with segments shorter than one strobe period gives no pulse.
- R6: `edgePol` = 0 counts high-to-low changes of the accepted level, and `edgePol` = 1 counts low-to-high changes. The other direction gives no pulse.
- R7: Each accepted qualifying change gives exactly one pulse, one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinRaw | input | 1 | Asynchronous external event pin |
| filterEn | input | 1 | 1 = noise rejection on, 0 = direct pass |
| edgePol | input | 1 | 0 = count falling edges, 1 = count rising edges |
| sampleRef | input | 1 | Slow sampling strobe, asynchronous level |
| countPulse | output | 1 | One-clock count pulse per accepted qualifying edge |

## Verification
The hardest case to reach from the ports is a pending change that has seen exactly one strobe falling edge and is then cancelled by the pin returning. The bench produces it with chatter segments 14 system clocks long against a strobe period of 16. Every segment then overlaps at most one falling edge, and the counter must restart over and over across all strobe phases. Glitches are also started at several phase offsets from the strobe. The measured accept latency is checked against both bounds.

// File: rtl/evt_filter_pkg.sv
package evt_filter_pkg;
  // datapath -> control
  typedef struct packed {
    logic mismatch;   // synchronized pin differs from accepted level
    logic refFall;    // falling edge of sampling strobe this cycle
  } dpStatus_t;

  // control -> datapath
  typedef struct packed {
    logic takeLevel;  // load synchronized pin into accepted level
  } ctrlStrobe_t;
endpackage

// File: rtl/evt_filter_dp.sv
module evt_filter_dp
  import evt_filter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinRaw,
  input  logic        sampleRef,
  input  logic        edgePol,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        pinSync,
  output logic        accLevel,
  output logic        countPulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] pinPipe;
  logic [LAST:0] refPipe;
  logic          refPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pinPipe <= '1;
          refPipe <= '0;
        end else begin
          pinPipe <= pinRaw;
          refPipe <= sampleRef;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pinPipe <= '1;
          refPipe <= '0;
        end else begin
          pinPipe <= {pinPipe[LAST-1:0], pinRaw};
          refPipe <= {refPipe[LAST-1:0], sampleRef};
        end
      end
    end
  endgenerate

  assign pinSync = pinPipe[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev    <= 1'b0;
      accLevel   <= 1'b1;
      countPulse <= 1'b0;
    end else begin
      refPrev    <= refPipe[LAST];
      countPulse <= strobe.takeLevel && (pinSync == edgePol);
      if (strobe.takeLevel) accLevel <= pinSync;
    end
  end

  always_comb begin
    status.mismatch = (pinSync != accLevel);
    status.refFall  = refPrev & ~refPipe[LAST];
  end
endmodule

// File: rtl/evt_filter_ctrl.sv
module evt_filter_ctrl
  import evt_filter_pkg::*;
#(
  parameter int REF_FALLS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        filterEn,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic [$clog2(REF_FALLS+1)-1:0] fallCnt
);
  localparam int CNT_W = $clog2(REF_FALLS + 1);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(REF_FALLS - 1);

  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    strobe.takeLevel = 1'b0;
    nextCnt          = fallCnt;
    if (!status.mismatch) begin
      nextCnt = '0;                      // change withdrawn or none pending
    end else if (!filterEn) begin
      strobe.takeLevel = 1'b1;
      nextCnt          = '0;
    end else if (status.refFall) begin
      if (fallCnt == LAST_FALL) begin
        strobe.takeLevel = 1'b1;
        nextCnt          = '0;
      end else begin
        nextCnt = fallCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) fallCnt <= '0;
    else       fallCnt <= nextCnt;
  end
endmodule

// File: rtl/evt_noise_filter.sv
module evt_noise_filter
  import evt_filter_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_FALLS   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  input  logic filterEn,
  input  logic edgePol,
  input  logic sampleRef,
  output logic countPulse
);
  localparam int CNT_W = $clog2(REF_FALLS + 1);

  dpStatus_t        status;
  ctrlStrobe_t      strobe;
  logic             pinSync;
  logic             accLevel;
  logic [CNT_W-1:0] fallCnt;

  evt_filter_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .sampleRef(sampleRef),
    .edgePol(edgePol), .strobe(strobe), .status(status),
    .pinSync(pinSync), .accLevel(accLevel), .countPulse(countPulse)
  );

  evt_filter_ctrl #(.REF_FALLS(REF_FALLS)) u_ctrl (
    .clk(clk), .rstN(rstN), .filterEn(filterEn), .status(status),
    .strobe(strobe), .fallCnt(fallCnt)
  );
endmodule

// File: rtl/evt_filter_checker.sv
module evt_filter_checker #(
  parameter int REF_FALLS = 2,
  parameter int CNT_W     = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             filterEn,
  input logic             edgePol,
  input logic             countPulse,
  input logic             accLevel,
  input logic             pinSync,
  input logic             refFall,
  input logic [CNT_W-1:0] fallCnt
);
  a_r7_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |=> !countPulse);

  a_r1_pulse_needs_change: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |-> (accLevel != $past(accLevel)));

  a_r6_pulse_polarity: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |-> (accLevel == $past(edgePol)));

  a_r3_accept_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (filterEn && $past(filterEn) && accLevel != $past(accLevel)) |-> $past(refFall));

  a_r2_direct_pass: assert property (@(posedge clk) disable iff (!rstN)
    $past(!filterEn) |-> (accLevel == $past(pinSync)));

  a_r5_match_restarts: assert property (@(posedge clk) disable iff (!rstN)
    $past(pinSync == accLevel) |-> (fallCnt == '0));

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt < CNT_W'(REF_FALLS));
endmodule

bind evt_noise_filter evt_filter_checker #(.REF_FALLS(REF_FALLS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .filterEn(filterEn), .edgePol(edgePol),
  .countPulse(countPulse), .accLevel(accLevel), .pinSync(pinSync),
  .refFall(status.refFall), .fallCnt(fallCnt)
);

// File: tb/evt_noise_filter_bench.sv
`timescale 1ns/1ps
module evt_noise_filter_bench;
  logic clk = 1'b0, rstN = 1'b0, pinRaw = 1'b1, filterEn = 1'b1, edgePol = 1'b0;
  logic sampleRef = 1'b0, countPulse;
  logic refRun = 1'b0;
  int   tests = 0, fails = 0, pulses = 0, cyc = 0, lastPulseCyc = 0, refDiv = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  evt_noise_filter u_evt_noise_filter (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .filterEn(filterEn),
    .edgePol(edgePol), .sampleRef(sampleRef), .countPulse(countPulse)
  );

  // strobe: 16 system clocks per period
  always @(negedge clk) if (refRun) begin
    refDiv <= (refDiv == 7) ? 0 : refDiv + 1;
    if (refDiv == 7) sampleRef <= ~sampleRef;
  end

  // behavioural reference: queues for delays, integer count of strobe falls
  logic pinQ[$], refQ[$];
  bit   mAcc = 1'b1, mPulse = 1'b0, refLast = 1'b0;
  int   fallsSeen = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      pinQ = '{1'b1, 1'b1}; refQ = '{1'b0, 1'b0};
      mAcc = 1'b1; mPulse = 1'b0; refLast = 1'b0; fallsSeen = 0;
    end else begin
      bit s, r, fall, old;
      s = pinQ[0]; r = refQ[0];
      fall = refLast && !r;
      old = mAcc;
      if (s == mAcc) fallsSeen = 0;
      else if (!filterEn) begin mAcc = s; fallsSeen = 0; end
      else if (fall) begin
        fallsSeen++;
        if (fallsSeen >= 2) begin mAcc = s; fallsSeen = 0; end
      end
      mPulse = (mAcc != old) && (mAcc == edgePol);
      refLast = r;
      void'(pinQ.pop_front()); pinQ.push_back(pinRaw);
      void'(refQ.pop_front()); refQ.push_back(sampleRef);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R7 one-wide pulses, R3 timing)
  always @(negedge clk) begin
    cyc++;
    if (rstN && !done) begin
      check(countPulse === mPulse, "R7 model", countPulse, mPulse);
      if (countPulse) begin pulses++; lastPulseCyc = cyc; end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0;
    hold(4);
    check(countPulse === 1'b0, "R1 reset", countPulse, 0);
    rstN = 1'b1; refRun = 1'b1;
    hold(100);
    check(pulses == 0, "R1 idle high", pulses, 0);

    // R4 short glitches at several strobe phases
    for (int i = 0; i < 6; i++) begin
      hold(i * 3 + 1);
      pinRaw = 1'b0; hold(6); pinRaw = 1'b1; hold(40);
    end
    check(pulses == 0, "R4 glitch", pulses, 0);

    // R3 long low pulse accepted with bounded latency
    pulses = 0; pinRaw = 1'b0; t0 = cyc; hold(80);
    check(pulses == 1, "R3 accept", pulses, 1);
    check(lastPulseCyc - t0 > 16, "R3 min latency", lastPulseCyc - t0, 17);
    check(lastPulseCyc - t0 <= 40, "R3 max latency", lastPulseCyc - t0, 40);
    pulses = 0; pinRaw = 1'b1; hold(80);
    check(pulses == 0, "R6 rising ignored pol0", pulses, 0);

    // R5 chatter: each segment overlaps at most one strobe fall
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      pinRaw = 1'b0; hold(14); pinRaw = 1'b1; hold(14);
    end
    hold(40);
    check(pulses == 0, "R5 chatter", pulses, 0);
    // one near-miss then a real change: must need two fresh falls
    pulses = 0; pinRaw = 1'b0; hold(14); pinRaw = 1'b1; hold(3);
    pinRaw = 1'b0; t0 = cyc; hold(80);
    check(pulses == 1, "R5 restart accept", pulses, 1);
    check(lastPulseCyc - t0 > 16, "R5 restart latency", lastPulseCyc - t0, 17);
    pinRaw = 1'b1; hold(80);

    // R6 rising polarity
    edgePol = 1'b1; pulses = 0; pinRaw = 1'b0; hold(80);
    check(pulses == 0, "R6 falling ignored pol1", pulses, 0);
    pinRaw = 1'b1; hold(80);
    check(pulses == 1, "R6 rising counted", pulses, 1);

    // R2 direct pass with two-stage synchronizer
    edgePol = 1'b0; filterEn = 1'b0; hold(10); pulses = 0;
    pinRaw = 1'b0;
    @(negedge clk); check(countPulse === 1'b0, "R2 edge1", countPulse, 0);
    @(negedge clk); check(countPulse === 1'b0, "R2 edge2", countPulse, 0);
    @(negedge clk); check(countPulse === 1'b1, "R2 edge3", countPulse, 1);
    @(negedge clk); check(countPulse === 1'b0, "R7 width", countPulse, 0);
    pinRaw = 1'b1; hold(10);
    check(pulses == 1, "R2 rising ignored", pulses, 1);
    pinRaw = 1'b0; hold(2); pinRaw = 1'b1; hold(10);
    check(pulses == 2, "R2 short pulse passes", pulses, 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule